// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath shares one ALU and one memory port across several clock cycles per instruction. Each instruction passes through a fixed set of steps: fetch, decode with register read, an execute or address step, an optional memory access, and an optional register write-back. A 6-bit opcode taken from the instruction register selects the path through these steps. Every datapath control line is a function of the current step alone, so the sequencer behaves as a Moore machine.

Five instruction kinds are supported: word load, word store, register-to-register arithmetic, branch when equal, and unconditional jump. Loads take five cycles, stores and arithmetic take four, and branches and jumps take three. The ALU serves three purposes. It adds 4 to the program counter during fetch, it forms the branch target during decode, and it does the instruction's own work after decode. An opcode that is not recognised sends the machine back to fetch and raises a one-cycle flag. The 4-bit step index is brought out so that the datapath or a debugger can follow the sequence.

All outputs come straight from flip-flops. The control register is loaded from the encoding of the next step, so the controls always match the step index shown in the same cycle.

Top module: `mcc_control_fsm`

## Requirements
- R1: A synchronous active-high reset, asserted at any step, puts the machine in step 0 at the next clock edge and clears the illegal flag. While reset is held, the outputs carry the step-0 encoding.
- R2: Step 0 (fetch) drives pc_wr=1, mem_rd=1, ir_load=1, alu_b_sel=01 and every other control at 0. The next step is always 1.
- R3: Step 1 (decode) drives alu_b_sel=11 and every other control at 0. From decode the opcode selects the next step: 100011 (load) and 101011 (store) go to 2, 000000 (register arithmetic) goes to 6, 000100 (branch) goes to 8, and 000010 (jump) goes to 9.
- R4: Step 2 (address) drives alu_a_sel=1, alu_b_sel=10 and every other control at 0. It goes to step 3 when the opcode is load and to step 5 otherwise.
- R5: Step 3 (memory read) drives mem_rd=1 and addr_sel=1 and goes to step 4. Step 4 (load write-back) drives rf_wr=1 and wb_from_mem=1 with rf_dst_sel=0, then goes to step 0. All other controls are 0 in both steps.
- R6: Step 5 (memory write) drives mem_wr=1 and addr_sel=1, with all other controls at 0, and then goes to step 0.
- R7: Step 6 (register execute) drives alu_a_sel=1, alu_mode=10 and alu_b_sel=00. Step 7 (register write-back) drives rf_wr=1, rf_dst_sel=1 and wb_from_mem=0. All other controls are 0 in both steps. Step 6 always goes to 7 and step 7 goes to 0, whatever the opcode is after decode.
- R8: Step 8 (branch) drives alu_a_sel=1, alu_mode=01, pc_wr_cond=1 and pc_src=01, with all other controls at 0, and then goes to step 0.
- R9: Step 9 (jump) drives pc_wr=1 and pc_src=10, with all other controls at 0, and then goes to step 0.
- R10: In decode, an opcode other than the five listed sends the machine to step 0. illegal_op is then high for exactly that one fetch cycle.
- R11: mem_rd and mem_wr are never high together, and illegal_op is high only while in step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| pc_wr | output | 1 | Program counter write, unconditional |
| pc_wr_cond | output | 1 | Program counter write when the ALU reports equality |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_from_mem | output | 1 | Register write data source: 1 memory data register, 0 ALU result |
| ir_load | output | 1 | Instruction register load |
| pc_src | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU function class: 00 add, 01 subtract, 10 by function field |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| state_idx | output | 4 | Current step index |
| illegal_op | output | 1 | One-cycle flag for an unrecognised opcode |

## Verification
The properties take only one thing for granted about the inputs: the opcode is meaningful when it is sampled in decode and in the address step. Any value is allowed at other times, including values with no defined meaning. The stimulus keeps the intended opcode steady through decode and the address step, so a store is not read as a load. Elsewhere the stimulus changes the opcode on purpose, for example while an arithmetic instruction is still in progress, to show that the sequence does not react to it. Reset is released and applied again on a falling edge, never next to a rising one.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W  = 4;
  localparam int OPC_W = 6;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRCH   = 4'd8,
    ST_JUMP   = 4'd9
  } state_e;

  typedef enum logic [2:0] {
    CLS_LOAD  = 3'd0,
    CLS_STORE = 3'd1,
    CLS_REG   = 3'd2,
    CLS_BR    = 3'd3,
    CLS_JMP   = 3'd4,
    CLS_BAD   = 3'd5
  } op_class_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_from_mem;
    logic       ir_load;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_op_decode.sv
module mcc_op_decode
  import mcc_pkg::*;
#(
  parameter int             OW       = 6,
  parameter logic [OW-1:0]  OP_LOAD  = 6'b100011,
  parameter logic [OW-1:0]  OP_STORE = 6'b101011,
  parameter logic [OW-1:0]  OP_REG   = 6'b000000,
  parameter logic [OW-1:0]  OP_BR    = 6'b000100,
  parameter logic [OW-1:0]  OP_JMP   = 6'b000010
) (
  input  logic [OW-1:0] opcode,
  output op_class_e     cls
);

  always_comb begin
    if (opcode == OP_LOAD)       cls = CLS_LOAD;
    else if (opcode == OP_STORE) cls = CLS_STORE;
    else if (opcode == OP_REG)   cls = CLS_REG;
    else if (opcode == OP_BR)    cls = CLS_BR;
    else if (opcode == OP_JMP)   cls = CLS_JMP;
    else                         cls = CLS_BAD;
  end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e    cur,
  input  op_class_e cls,
  output state_e    nxt,
  output logic      bad_op
);

  always_comb begin
    nxt    = ST_FETCH;
    bad_op = 1'b0;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (cls)
          CLS_LOAD, CLS_STORE: nxt = ST_ADDR;
          CLS_REG:             nxt = ST_REXE;
          CLS_BR:              nxt = ST_BRCH;
          CLS_JMP:             nxt = ST_JUMP;
          default: begin
            nxt    = ST_FETCH;
            bad_op = 1'b1;
          end
        endcase
      end
      ST_ADDR:   nxt = (cls == CLS_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:   nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RWB;
      ST_LDWB, ST_STWR, ST_RWB, ST_BRCH, ST_JUMP: nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_encode.sv
module mcc_ctrl_encode
  import mcc_pkg::*;
(
  input  state_e st,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = CTRL_IDLE;
    unique case (st)
      ST_FETCH: begin
        ctrl.mem_rd    = 1'b1;
        ctrl.ir_load   = 1'b1;
        ctrl.pc_wr     = 1'b1;
        ctrl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctrl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_b_sel = 2'b10;
      end
      ST_LDRD: begin
        ctrl.mem_rd   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rf_wr       = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      ST_STWR: begin
        ctrl.mem_wr   = 1'b1;
        ctrl.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctrl.alu_a_sel = 1'b1;
        ctrl.alu_mode  = 2'b10;
      end
      ST_RWB: begin
        ctrl.rf_wr      = 1'b1;
        ctrl.rf_dst_sel = 1'b1;
      end
      ST_BRCH: begin
        ctrl.alu_a_sel  = 1'b1;
        ctrl.alu_mode   = 2'b01;
        ctrl.pc_wr_cond = 1'b1;
        ctrl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_src = 2'b10;
      end
      default: ctrl = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/mcc_control_fsm.sv
module mcc_control_fsm
  import mcc_pkg::*;
#(
  parameter int                OW       = OPC_W,
  parameter logic [OW-1:0]     OP_LOAD  = 6'b100011,
  parameter logic [OW-1:0]     OP_STORE = 6'b101011,
  parameter logic [OW-1:0]     OP_REG   = 6'b000000,
  parameter logic [OW-1:0]     OP_BR    = 6'b000100,
  parameter logic [OW-1:0]     OP_JMP   = 6'b000010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OW-1:0]    opcode,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_from_mem,
  output logic             ir_load,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_mode,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr,
  output logic             rf_dst_sel,
  output logic [ST_W-1:0]  state_idx,
  output logic             illegal_op
);

  op_class_e cls;
  state_e    state_q, state_d, load_st;
  logic      bad_op;
  ctrl_t     ctrl_d, ctrl_q;
  logic      illegal_q;

  mcc_op_decode #(
    .OW(OW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_REG(OP_REG), .OP_BR(OP_BR), .OP_JMP(OP_JMP)
  ) u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  mcc_next_state u_nxt (
    .cur    (state_q),
    .cls    (cls),
    .nxt    (state_d),
    .bad_op (bad_op)
  );

  // Encode the state about to be entered so the control register
  // lines up with the state register in the same cycle.
  assign load_st = rst ? ST_FETCH : state_d;

  mcc_ctrl_encode u_enc (
    .st   (load_st),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q   <= load_st;
    ctrl_q    <= ctrl_d;
    illegal_q <= rst ? 1'b0 : bad_op;
  end

  assign pc_wr       = ctrl_q.pc_wr;
  assign pc_wr_cond  = ctrl_q.pc_wr_cond;
  assign addr_sel    = ctrl_q.addr_sel;
  assign mem_rd      = ctrl_q.mem_rd;
  assign mem_wr      = ctrl_q.mem_wr;
  assign wb_from_mem = ctrl_q.wb_from_mem;
  assign ir_load     = ctrl_q.ir_load;
  assign pc_src      = ctrl_q.pc_src;
  assign alu_mode    = ctrl_q.alu_mode;
  assign alu_a_sel   = ctrl_q.alu_a_sel;
  assign alu_b_sel   = ctrl_q.alu_b_sel;
  assign rf_wr       = ctrl_q.rf_wr;
  assign rf_dst_sel  = ctrl_q.rf_dst_sel;
  assign state_idx   = state_q;
  assign illegal_op  = illegal_q;

endmodule

// File: rtl/mcc_control_fsm_chk.sv
module mcc_control_fsm_chk #(
  parameter int            OW       = 6,
  parameter logic [OW-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OW-1:0] OP_STORE = 6'b101011,
  parameter logic [OW-1:0] OP_REG   = 6'b000000,
  parameter logic [OW-1:0] OP_BR    = 6'b000100,
  parameter logic [OW-1:0] OP_JMP   = 6'b000010
) (
  input logic          clk,
  input logic          rst,
  input logic [OW-1:0] opcode,
  input logic          pc_wr,
  input logic          ir_load,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          rf_wr,
  input logic [3:0]    state_idx,
  input logic          illegal_op
);

  logic known;
  assign known = (opcode == OP_LOAD) || (opcode == OP_STORE) || (opcode == OP_REG) ||
                 (opcode == OP_BR) || (opcode == OP_JMP);

  AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> (state_idx == 4'd0 && !illegal_op)); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd0 |=> state_idx == 4'd1); // R2
  AST_FETCH_CONTROLS: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd0 |-> (pc_wr && ir_load && mem_rd && !rf_wr)); // R2
  AST_DECODE_MEMREF: assert property (@(posedge clk) disable iff (rst) (state_idx == 4'd1 && (opcode == OP_LOAD || opcode == OP_STORE)) |=> state_idx == 4'd2); // R3
  AST_DECODE_JUMP: assert property (@(posedge clk) disable iff (rst) (state_idx == 4'd1 && opcode == OP_JMP) |=> state_idx == 4'd9); // R3
  AST_ADDR_SPLIT: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd2 |=> (state_idx == 4'd3 || state_idx == 4'd5)); // R4
  AST_LOAD_READ_NEXT: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd3 |=> state_idx == 4'd4); // R5
  AST_STORE_RETURN: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd5 |=> state_idx == 4'd0); // R6
  AST_REG_CHAIN: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd6 |=> state_idx == 4'd7); // R7
  AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd8 |=> state_idx == 4'd0); // R8
  AST_JUMP_RETURN: assert property (@(posedge clk) disable iff (rst) state_idx == 4'd9 |=> state_idx == 4'd0); // R9
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst) (state_idx == 4'd1 && !known) |=> (illegal_op && state_idx == 4'd0)); // R10
  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (rst) illegal_op |=> !illegal_op); // R10
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R11
  AST_ILLEGAL_IN_FETCH: assert property (@(posedge clk) disable iff (rst) illegal_op |-> state_idx == 4'd0); // R11

endmodule

bind mcc_control_fsm mcc_control_fsm_chk #(
  .OW(OW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
  .OP_REG(OP_REG), .OP_BR(OP_BR), .OP_JMP(OP_JMP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .opcode     (opcode),
  .pc_wr      (pc_wr),
  .ir_load    (ir_load),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .rf_wr      (rf_wr),
  .state_idx  (state_idx),
  .illegal_op (illegal_op)
);

// File: tb/tb_mcc_control_fsm.sv
module tb_mcc_control_fsm;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_from_mem, ir_load;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic       alu_a_sel, rf_wr, rf_dst_sel, illegal_op;
  logic [3:0] state_idx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_control_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
    .ir_load(ir_load), .pc_src(pc_src), .alu_mode(alu_mode),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
    .rf_dst_sel(rf_dst_sel), .state_idx(state_idx), .illegal_op(illegal_op)
  );

  // Expected control word per step, in the order:
  // pc_wr pc_wr_cond addr_sel mem_rd mem_wr wb_from_mem ir_load pc_src alu_mode alu_a_sel alu_b_sel rf_wr rf_dst_sel
  function automatic logic [15:0] exp_ctrl(input int s);
    logic pw, pwc, ads, mr, mw, wfm, irl, as, rw, rd;
    logic [1:0] ps, am, bs;
    {pw, pwc, ads, mr, mw, wfm, irl, as, rw, rd} = '0;
    {ps, am, bs} = '0;
    case (s)
      0: begin pw = 1; mr = 1; irl = 1; bs = 2'b01; end
      1: bs = 2'b11;
      2: begin as = 1; bs = 2'b10; end
      3: begin mr = 1; ads = 1; end
      4: begin rw = 1; wfm = 1; end
      5: begin mw = 1; ads = 1; end
      6: begin as = 1; am = 2'b10; end
      7: begin rw = 1; rd = 1; end
      8: begin as = 1; am = 2'b01; pwc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, ads, mr, mw, wfm, irl, ps, am, as, bs, rw, rd};
  endfunction

  function automatic logic [15:0] obs_ctrl();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, wb_from_mem, ir_load,
            pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
  endfunction

  task automatic check_now(input int exp_s, input logic exp_ill, input string tag);
    logic [15:0] ec;
    ec = exp_ctrl(exp_s);
    checks++;
    if (state_idx !== exp_s[3:0] || obs_ctrl() !== ec || illegal_op !== exp_ill) begin
      fails++;
      $display("FAIL %s: state=%0d ctrl=%b ill=%b expected state=%0d ctrl=%b ill=%b",
               tag, state_idx, obs_ctrl(), illegal_op, exp_s, ec, exp_ill);
    end
  endtask

  task automatic step(input int exp_s, input logic exp_ill, input string tag);
    @(posedge clk);
    @(negedge clk);
    check_now(exp_s, exp_ill, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now(0, 1'b0, "R1 reset state");
    rst = 1'b0;
  endtask

  task automatic t_load();
    opcode = 6'b100011;
    step(1, 1'b0, "R2 load fetch->decode");
    step(2, 1'b0, "R3 load dispatch");
    step(3, 1'b0, "R4 load address");
    step(4, 1'b0, "R5 load read");
    step(0, 1'b0, "R5 load writeback return");
  endtask

  task automatic t_store();
    opcode = 6'b101011;
    step(1, 1'b0, "R2 store decode");
    step(2, 1'b0, "R3 store dispatch");
    step(5, 1'b0, "R4 store address split");
    step(0, 1'b0, "R6 store return");
  endtask

  task automatic t_regop();
    opcode = 6'b000000;
    step(1, 1'b0, "R2 reg decode");
    step(6, 1'b0, "R3 reg dispatch");
    opcode = 6'b000100;
    step(7, 1'b0, "R7 reg execute ignores new opcode");
    opcode = 6'b111111;
    step(0, 1'b0, "R7 reg writeback return");
  endtask

  task automatic t_branch();
    opcode = 6'b000100;
    step(1, 1'b0, "R2 branch decode");
    step(8, 1'b0, "R3 branch dispatch");
    step(0, 1'b0, "R8 branch return");
  endtask

  task automatic t_jump();
    opcode = 6'b000010;
    step(1, 1'b0, "R2 jump decode");
    step(9, 1'b0, "R3 jump dispatch");
    step(0, 1'b0, "R9 jump return");
  endtask

  task automatic t_illegal(input logic [5:0] op);
    opcode = op;
    step(1, 1'b0, "R10 illegal decode");
    step(0, 1'b1, "R10 illegal flag in fetch");
    opcode = 6'b000010;
    step(1, 1'b0, "R10 illegal flag one cycle");
    step(9, 1'b0, "R10 recovery jump");
    step(0, 1'b0, "R9 recovery return");
  endtask

  task automatic t_reset_mid();
    opcode = 6'b100011;
    step(1, 1'b0, "R2 mid-reset decode");
    step(2, 1'b0, "R3 mid-reset address");
    rst = 1'b1;
    step(0, 1'b0, "R1 reset from address step");
    rst = 1'b0;
    step(1, 1'b0, "R1 resume after reset");
    opcode = 6'b111110;
    step(0, 1'b1, "R10 illegal after reset");
    rst = 1'b1;
    step(0, 1'b0, "R1 reset clears flag");
    rst = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_regop();
    t_branch();
    t_jump();
    t_illegal(6'b111111);
    t_illegal(6'b100010);
    t_store();
    t_load();
    t_reset_mid();
    t_branch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule